// File: doc/BRIEF.md
# Biphase-Mark Digital Audio Transmitter

This block turns a stream of stereo sample pairs into one line-coded serial output for a consumer digital audio link. Each sample is placed in a 32-slot subframe that opens with a four-slot sync preamble and ends with validity, user, channel-status and parity flags. The slots after the preamble are sent with biphase-mark coding, where every cell starts with a level change and a one adds a second change in mid-cell. Subframes alternate left and right and are counted in blocks of 384. The first subframe of each block carries a preamble of its own.

A two-bit mode input selects one of three modes. In the off mode the line rests low. In the zero mode the framing is complete but every audio slot is zero. In the live mode the real samples are sent. The output only runs while the disc decoder reports normal constant-linear-velocity operation. In any other decoder state the block behaves as if it were off. The line advances by one half-cell per pulse of a tick input that runs at twice the bit rate. The source offers a new pair on a valid/ready handshake, and the pair is taken only where a left subframe starts.

Top module: `biphase_tx_top`

## Requirements
- R1: While `modeSel` is 0 (off) or 3, or while `clvMode` is low, `lineOut` is 0 from the next clock on and `sampleReady` stays low.
- R2: Every slot from 4 to 31 takes two ticks, one half-cell per tick. The line toggles at the start of every such slot, and toggles again at mid-slot exactly when the slot's bit is 1.
- R3: Slots 4..27 carry the audio LSB first, with a SAMPLE_W-bit sample left-justified so that its MSB is in slot 27 and the unused lower slots are 0. Slot 28 (validity) and slot 29 (user) are 0, slot 30 is channel status, and slot 31 makes the count of ones in slots 4..31 even.
- R4: If L is the line level before a subframe, its first eight half-cells equal the pattern XOR L, sent from the leftmost bit. The pattern is 11101000 for a block-start subframe, 11100010 for any other left subframe and 11100100 for a right subframe.
- R5: Subframes alternate left, right, beginning with left. Subframe 0 of each 384-subframe block gets the block-start preamble, and subframe 384 starts the next block.
- R6: The channel-status bit of frame f, where f is the subframe index in the block divided by 2, is bit f of CS_WORD for f < 32 and 0 otherwise. Both subframes of a frame carry the same bit.
- R7: `sampleReady` is high only in the clock cycle whose tick starts a left subframe. The pair on `leftIn`/`rightIn` is taken if `sampleValid` is high in that cycle, and that left subframe and the right one after it send the pair.
- R8: If `sampleValid` is low when a left subframe starts, the last pair taken is sent again.
- R9: In the zero mode (`modeSel` = 1) slots 4..27 are 0. The preambles, the channel status and the parity follow the same rules as in the live mode (`modeSel` = 2).
- R10: When the block leaves the off state, the first tick emits the first half-cell of a block-start subframe.
- R11: `lineOut` changes only on a clock with `tick` high, or when it is forced low by R1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Half-cell advance pulse at twice the bit rate |
| modeSel | input | 2 | 0 off, 1 zeroed audio, 2 live audio, 3 treated as off |
| clvMode | input | 1 | High while the decoder is in normal constant-linear-velocity mode |
| sampleValid | input | 1 | A sample pair is offered |
| sampleReady | output | 1 | The offered pair is taken in this cycle if valid |
| leftIn | input | SAMPLE_W | Left sample |
| rightIn | input | SAMPLE_W | Right sample |
| lineOut | output | 1 | Biphase-mark line output |

## Verification
The properties assume that `tick` is a one-cycle pulse with at least one idle clock between pulses. The cell-edge and preamble-edge properties would be meaningless if every clock were a tick. They also assume that mode and decoder-state changes are synchronous inputs that need no filtering. The bench drives `tick` high for one clock out of every two and changes `modeSel`, `clvMode` and the sample inputs only at falling edges while `tick` is low. It changes samples only after a left subframe has begun, so the data taken by the handshake is always known.

// File: rtl/biphase_tx_pkg.sv
package biphase_tx_pkg;

  localparam int SUBFRAME_SLOTS = 32;
  localparam int SLOT_W         = 5;
  localparam int PRE_SLOTS      = 4;
  localparam int AUDIO_SLOTS    = 24;
  localparam int VAL_SLOT       = PRE_SLOTS + AUDIO_SLOTS;
  localparam int USR_SLOT       = VAL_SLOT + 1;
  localparam int CS_SLOT        = VAL_SLOT + 2;
  localparam int PAR_SLOT       = VAL_SLOT + 3;
  localparam int CS_FRAMES      = 32;

  // Preamble patterns, leftmost half-cell first, relative to a low start level.
  localparam logic [7:0] PRE_BLOCK = 8'b1110_1000;
  localparam logic [7:0] PRE_LEFT  = 8'b1110_0010;
  localparam logic [7:0] PRE_RIGHT = 8'b1110_0100;

  typedef enum logic [1:0] {
    MODE_OFF  = 2'd0,
    MODE_ZERO = 2'd1,
    MODE_LIVE = 2'd2,
    MODE_RSVD = 2'd3
  } txMode_e;

  typedef struct packed {
    logic              run;     // framing active
    logic              step;    // emit one half-cell this cycle
    logic              load;    // first half-cell of a subframe
    logic              left;    // current subframe is left
    logic              zero;    // zero-payload mode
    logic              inPre;   // current slot is a preamble slot
    logic              preBit;  // relative preamble level for this half-cell
    logic              half;    // 0 first half, 1 second half of a cell
    logic              csBit;   // channel-status bit of this frame
    logic [SLOT_W-1:0] slot;    // current slot index
  } txStrobe_t;

endpackage

// File: rtl/biphase_tx_ctrl.sv
module biphase_tx_ctrl
  import biphase_tx_pkg::*;
#(
  parameter int          BLOCK_SUBS = 384,
  parameter logic [31:0] CS_WORD    = 32'h0200_0004
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic [1:0] modeSel,
  input  logic       clvMode,
  output txStrobe_t  stb,
  output logic       sampleReady
);

  localparam int SUB_W = $clog2(BLOCK_SUBS);

  logic             runNow;
  logic             halfQ;
  logic [SLOT_W-1:0] slotQ;
  logic [SUB_W-1:0] subQ;
  logic [SUB_W-2:0] frameIdx;
  logic [2:0]       halfIdx;
  logic [7:0]       prePat;
  logic             lastSlot;
  logic             lastSub;

  assign runNow   = clvMode && ((modeSel == MODE_ZERO) || (modeSel == MODE_LIVE));
  assign lastSlot = (slotQ == SLOT_W'(SUBFRAME_SLOTS - 1));
  assign lastSub  = (subQ == SUB_W'(BLOCK_SUBS - 1));

  always_ff @(posedge clk) begin
    if (!rstN || !runNow) begin
      halfQ <= 1'b0;
      slotQ <= '0;
      subQ  <= '0;
    end else if (tick) begin
      halfQ <= ~halfQ;
      if (halfQ) begin
        if (lastSlot) begin
          slotQ <= '0;
          subQ  <= lastSub ? '0 : subQ + 1'b1;
        end else begin
          slotQ <= slotQ + 1'b1;
        end
      end
    end
  end

  assign frameIdx = subQ[SUB_W-1:1];
  assign halfIdx  = {slotQ[1:0], halfQ};

  always_comb begin
    if (subQ == '0)      prePat = PRE_BLOCK;
    else if (!subQ[0])   prePat = PRE_LEFT;
    else                 prePat = PRE_RIGHT;
  end

  always_comb begin
    stb        = '0;
    stb.run    = runNow;
    stb.step   = runNow && tick;
    stb.load   = runNow && tick && (slotQ == '0) && !halfQ;
    stb.left   = !subQ[0];
    stb.zero   = (modeSel == MODE_ZERO);
    stb.inPre  = (slotQ < SLOT_W'(PRE_SLOTS));
    stb.preBit = prePat[3'd7 - halfIdx];
    stb.half   = halfQ;
    stb.csBit  = (32'(frameIdx) < CS_FRAMES) ? CS_WORD[frameIdx[4:0]] : 1'b0;
    stb.slot   = slotQ;
  end

  assign sampleReady = stb.load && stb.left;

endmodule

// File: rtl/biphase_tx_dp.sv
module biphase_tx_dp
  import biphase_tx_pkg::*;
#(
  parameter int SAMPLE_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  txStrobe_t           stb,
  input  logic                sampleValid,
  input  logic [SAMPLE_W-1:0] leftIn,
  input  logic [SAMPLE_W-1:0] rightIn,
  output logic                lineOut
);

  localparam int SMP_LO = PRE_SLOTS + AUDIO_SLOTS - SAMPLE_W;

  logic [SAMPLE_W-1:0]       leftQ, rightQ, curLeft, smpSel;
  logic [SUBFRAME_SLOTS-1:0] wordNext, wordQ;
  logic                      startLvlQ, lineQ, accept;

  assign accept  = stb.load && stb.left && sampleValid;
  assign curLeft = accept ? leftIn : leftQ;
  assign smpSel  = stb.left ? curLeft : rightQ;

  always_comb begin
    wordNext = '0;
    if (!stb.zero) wordNext[SMP_LO +: SAMPLE_W] = smpSel;
    wordNext[VAL_SLOT] = 1'b0;
    wordNext[USR_SLOT] = 1'b0;
    wordNext[CS_SLOT]  = stb.csBit;
    wordNext[PAR_SLOT] = ^wordNext[PAR_SLOT-1:PRE_SLOTS];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      leftQ     <= '0;
      rightQ    <= '0;
      wordQ     <= '0;
      startLvlQ <= 1'b0;
    end else begin
      if (accept) begin
        leftQ  <= leftIn;
        rightQ <= rightIn;
      end
      if (stb.load) begin
        wordQ     <= wordNext;
        startLvlQ <= lineQ;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || !stb.run) begin
      lineQ <= 1'b0;
    end else if (stb.step) begin
      if (stb.inPre)          lineQ <= stb.preBit ^ (stb.load ? lineQ : startLvlQ);
      else if (!stb.half)     lineQ <= ~lineQ;
      else if (wordQ[stb.slot]) lineQ <= ~lineQ;
    end
  end

  assign lineOut = lineQ;

endmodule

// File: rtl/biphase_tx_top.sv
module biphase_tx_top
  import biphase_tx_pkg::*;
#(
  parameter int          SAMPLE_W   = 16,
  parameter int          BLOCK_SUBS = 384,
  parameter logic [31:0] CS_WORD    = 32'h0200_0004
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                tick,
  input  logic [1:0]          modeSel,
  input  logic                clvMode,
  input  logic                sampleValid,
  output logic                sampleReady,
  input  logic [SAMPLE_W-1:0] leftIn,
  input  logic [SAMPLE_W-1:0] rightIn,
  output logic                lineOut
);

  txStrobe_t ctlStb;

  biphase_tx_ctrl #(.BLOCK_SUBS(BLOCK_SUBS), .CS_WORD(CS_WORD)) u_ctrl (
    .clk(clk), .rstN(rstN), .tick(tick), .modeSel(modeSel), .clvMode(clvMode),
    .stb(ctlStb), .sampleReady(sampleReady)
  );

  biphase_tx_dp #(.SAMPLE_W(SAMPLE_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(ctlStb), .sampleValid(sampleValid),
    .leftIn(leftIn), .rightIn(rightIn), .lineOut(lineOut)
  );

endmodule

// File: rtl/biphase_tx_chk.sv
module biphase_tx_chk
  import biphase_tx_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       tick,
  input logic [1:0] modeSel,
  input logic       clvMode,
  input logic       sampleReady,
  input logic       lineOut,
  input txStrobe_t  stb
);

  logic enabled;
  assign enabled = clvMode && ((modeSel == 2'd1) || (modeSel == 2'd2));

  // R1
  off_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enabled |=> !lineOut);

  // R1
  off_noready_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enabled |-> !sampleReady);

  // R7
  ready_on_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    sampleReady |-> (tick && stb.load && stb.left));

  // R11
  line_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !tick |=> ($stable(lineOut) || !lineOut));

  // R4
  pre_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.load |=> (lineOut != $past(lineOut)));

  // R2
  cell_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.step && !stb.inPre && !stb.half) |=> (lineOut != $past(lineOut)));

endmodule

bind biphase_tx_top biphase_tx_chk u_chk (
  .clk(clk), .rstN(rstN), .tick(tick), .modeSel(modeSel), .clvMode(clvMode),
  .sampleReady(sampleReady), .lineOut(lineOut), .stb(ctlStb)
);

// File: tb/tb_biphase_tx_top.sv
module tb_biphase_tx_top;

  localparam logic [31:0] CSW = 32'h0200_0004;
  localparam logic [7:0]  P_B = 8'b1110_1000;
  localparam logic [7:0]  P_M = 8'b1110_0010;
  localparam logic [7:0]  P_W = 8'b1110_0100;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tick = 1'b0;
  logic [1:0]  modeSel = 2'd0;
  logic        clvMode = 1'b1;
  logic        sampleValid = 1'b0;
  logic        sampleReady;
  logic [15:0] leftIn = '0;
  logic [15:0] rightIn = '0;
  logic        lineOut;

  int nChecks = 0;
  int nErrors = 0;
  logic lastLvl = 1'b0;
  int   subIdx = 0;

  always #5 clk = ~clk;

  biphase_tx_top dut (
    .clk(clk), .rstN(rstN), .tick(tick), .modeSel(modeSel), .clvMode(clvMode),
    .sampleValid(sampleValid), .sampleReady(sampleReady),
    .leftIn(leftIn), .rightIn(rightIn), .lineOut(lineOut)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic halfStep(output logic lvl, output logic rdy);
    @(negedge clk);
    tick = 1'b1;
    #1 rdy = sampleReady;
    @(negedge clk);
    tick = 1'b0;
    lvl = lineOut;
  endtask

  function automatic logic [31:0] expWord(input logic [15:0] s, input bit zero, input int sub);
    logic [31:0] w;
    int f;
    w = '0;
    if (!zero) w[27:12] = s;
    f = (sub % 384) / 2;
    w[30] = (f < 32) ? CSW[f] : 1'b0;
    w[31] = ^w[30:4];
    return w;
  endfunction

  function automatic logic [7:0] expPre(input int sub);
    int s;
    s = sub % 384;
    if (s == 0) return P_B;
    if (s % 2 == 0) return P_M;
    return P_W;
  endfunction

  task automatic recvSub(output logic [31:0] word, output logic [7:0] pre,
                         output bit codeOk, output logic rdy);
    logic [63:0] h;
    logic startLvl, prev, r, l;
    startLvl = lastLvl;
    rdy = 1'b0;
    for (int i = 0; i < 64; i++) begin
      halfStep(l, r);
      h[i] = l;
      if (i == 0) rdy = r;
    end
    for (int i = 0; i < 8; i++) pre[7-i] = h[i] ^ startLvl;
    codeOk = 1'b1;
    word = '0;
    prev = h[7];
    for (int c = 4; c < 32; c++) begin
      if (h[2*c] == prev) codeOk = 1'b0;
      word[c] = h[2*c] ^ h[2*c+1];
      prev = h[2*c+1];
    end
    lastLvl = h[63];
  endtask

  task automatic checkSub(input string req, input logic [15:0] s, input bit zero, input logic expRdy);
    logic [31:0] w;
    logic [7:0] p;
    bit ok;
    logic r;
    recvSub(w, p, ok, r);
    chk(p == expPre(subIdx), {req, " R4 preamble"}, {24'd0, p}, {24'd0, expPre(subIdx)});
    chk(ok, {req, " R2 cell edges"}, {31'd0, ok}, 32'd1);
    chk(w == expWord(s, zero, subIdx), {req, " R3 word"}, w, expWord(s, zero, subIdx));
    chk(r == expRdy, {req, " R7 ready"}, {31'd0, r}, {31'd0, expRdy});
    subIdx++;
  endtask

  task automatic goOff();
    @(negedge clk);
    modeSel = 2'd0;
    repeat (3) @(negedge clk);
    lastLvl = 1'b0;
    subIdx = 0;
  endtask

  task automatic testReset();
    chk(lineOut == 1'b0, "R1 reset line", {31'd0, lineOut}, 32'd0);
    chk(sampleReady == 1'b0, "R1 reset ready", {31'd0, sampleReady}, 32'd0);
  endtask

  task automatic testQuiet(input logic [1:0] m, input logic clv, input string tag);
    logic l, r;
    bit anyHigh, anyRdy;
    @(negedge clk);
    modeSel = m; clvMode = clv; sampleValid = 1'b1;
    anyHigh = 0; anyRdy = 0;
    for (int i = 0; i < 80; i++) begin
      halfStep(l, r);
      if (l) anyHigh = 1;
      if (r) anyRdy = 1;
    end
    chk(!anyHigh, {tag, " R1 line static"}, {31'd0, anyHigh}, 32'd0);
    chk(!anyRdy, {tag, " R1 no ready"}, {31'd0, anyRdy}, 32'd0);
    @(negedge clk);
    clvMode = 1'b1; modeSel = 2'd0;
  endtask

  task automatic testLive();
    goOff();
    leftIn = 16'hA5C3; rightIn = 16'h1234; sampleValid = 1'b1;
    modeSel = 2'd2;
    checkSub("R10 R5 live left0", 16'hA5C3, 0, 1'b1);
    leftIn = 16'h8001; rightIn = 16'h7FFE;
    checkSub("R7 live right0", 16'h1234, 0, 1'b0);
    checkSub("R7 live left1", 16'h8001, 0, 1'b1);
    sampleValid = 1'b0; leftIn = 16'hDEAD; rightIn = 16'hBEEF;
    checkSub("R7 live right1", 16'h7FFE, 0, 1'b0);
    checkSub("R8 R6 repeat left", 16'h8001, 0, 1'b1);
    checkSub("R8 R6 repeat right", 16'h7FFE, 0, 1'b0);
  endtask

  task automatic testZero();
    goOff();
    leftIn = 16'hFFFF; rightIn = 16'h5555; sampleValid = 1'b1;
    modeSel = 2'd1;
    for (int k = 0; k < 6; k++) checkSub("R9 R10 zero", 16'h0000, 1, (k % 2 == 0));
  endtask

  task automatic testBlock();
    logic [31:0] w;
    logic [7:0] p;
    bit ok;
    logic r;
    int badPre, badWord, badCode;
    goOff();
    leftIn = 16'h0F0F; rightIn = 16'hF00F; sampleValid = 1'b1;
    modeSel = 2'd2;
    badPre = 0; badWord = 0; badCode = 0;
    for (int k = 0; k < 386; k++) begin
      recvSub(w, p, ok, r);
      if (p != expPre(subIdx)) badPre++;
      if (!ok) badCode++;
      if (w != expWord((subIdx % 2 == 0) ? 16'h0F0F : 16'hF00F, 0, subIdx)) badWord++;
      if (k == 50) chk(w[30] == 1'b1, "R6 frame 25 status", {31'd0, w[30]}, 32'd1);
      if (k == 70) chk(w[30] == 1'b0, "R6 frame 35 status", {31'd0, w[30]}, 32'd0);
      if (k == 384) chk(p == P_B, "R5 block wrap preamble", {24'd0, p}, {24'd0, P_B});
      if (k == 385) chk(p == P_W, "R5 wrap right preamble", {24'd0, p}, {24'd0, P_W});
      subIdx++;
    end
    chk(badPre == 0, "R5 R4 block preambles", badPre, 0);
    chk(badCode == 0, "R2 block coding", badCode, 0);
    chk(badWord == 0, "R3 R6 block words", badWord, 0);
  endtask

  task automatic testHold();
    logic l0;
    bit changed;
    goOff();
    modeSel = 2'd2;
    repeat (20) begin
      @(negedge clk);
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
      l0 = lineOut;
      changed = 0;
      repeat (3) begin
        @(negedge clk);
        if (lineOut != l0) changed = 1;
      end
      chk(!changed, "R11 line holds between ticks", {31'd0, changed}, 32'd0);
    end
    goOff();
  endtask

  initial begin
    #(10 * 190000);
    nErrors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", nChecks, nErrors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testQuiet(2'd0, 1'b1, "mode off");
    testQuiet(2'd2, 1'b0, "qclv live");
    testQuiet(2'd3, 1'b1, "mode rsvd");
    testLive();
    testZero();
    testHold();
    testBlock();
    goOff();
    chk(lineOut == 1'b0, "R1 final off", {31'd0, lineOut}, 32'd0);
    $display("CHECKS %0d ERRORS %0d", nChecks, nErrors);
    $finish;
  end

endmodule